// File: doc/BRIEF.md
# DMA Channel Request/Acknowledge Sequencer

This block is the control engine of one DMA channel. A peripheral asks for service by raising a request line. The channel answers on an acknowledge line and runs atomic transfers against an abstract bus datapath. It uses a per-beat request/done handshake for this. Each atomic transfer is either one beat or a fixed burst of four beats. Every completed atomic transfer lowers a transfer counter by one. When the counter reaches zero, the channel can raise a one-cycle terminal-count interrupt.

Software programs the channel by presenting a 32-bit control word and an initial count, and pulsing a start input while the channel is idle. The control word holds five bits:

- the acknowledge protocol (demand or handshake);
- a synchroniser-domain select, which is kept for readback only;
- the interrupt enable;
- the atomic size;
- the service mode (single or whole).

The request line always passes through a two-flop synchroniser before the sequencer acts on it.

Top module: `dma_req_ack_seq`

## Requirements
- R1: After reset, the acknowledge, beat request and interrupt outputs are low. The current count reads 0 and the control readback reads 0.
- R2: A start pulse taken while the acknowledge is low loads the count from `count_init_i` and the control word from `ctrl_i`. Both read back on the next cycle. Control bits: 31 = handshake mode, 30 = synchroniser select, 29 = interrupt enable, 28 = four-beat burst, 27 = whole service.
- R3: The request passes through two flops. When idle with a nonzero count, the acknowledge rises after the third rising clock edge that follows the request going high.
- R4: Handshake mode (bit 31 = 1), single service: after an atomic transfer that leaves a nonzero count, the acknowledge stays high until the synchronised request is low. It then drops, and the next transfer starts only after the request rises again.
- R5: Demand mode (bit 31 = 0), single service: after each atomic transfer the acknowledge is low for exactly one cycle. If the request is still high, the next transfer then starts without the request ever falling.
- R6: With bit 28 = 0 an atomic transfer is one beat; with bit 28 = 1 it is four beats. Each beat request stays high until `beat_done_i`, and the acknowledge is high whenever a beat is requested.
- R7: In single service (bit 27 = 0), each recognised request performs exactly one atomic transfer.
- R8: In whole service (bit 27 = 1), one recognised request runs atomic transfers back to back until the count is zero, with the acknowledge held high throughout.
- R9: Each completed atomic transfer lowers the count by one. With bit 29 = 1, `tc_irq_o` pulses for one cycle on the cycle the count first reads zero. With bit 29 = 0 it never pulses.
- R10: While the count is zero, the channel is idle, the acknowledge stays low whatever the request does, and only a start with a nonzero count resumes service.
- R11: Bit 30 has no effect on any output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load count and control word (taken only while idle) |
| count_init_i | input | CNT_W | Transfer count to load |
| ctrl_i | input | 32 | Control word to load |
| dreq_i | input | 1 | Asynchronous transfer request |
| dack_o | output | 1 | Transfer acknowledge |
| beat_req_o | output | 1 | Beat request to the datapath |
| beat_done_i | input | 1 | Datapath finished the current beat |
| cur_count_o | output | CNT_W | Remaining atomic transfers |
| ctrl_o | output | 32 | Control word readback |
| tc_irq_o | output | 1 | Terminal-count interrupt pulse |

## Verification
The bound checker watches every cycle for the following:

- a beat request without the acknowledge;
- interrupt pulses longer than one cycle, or pulses at a nonzero count or with the enable clear;
- the count moving by anything but one per completed transfer;
- the acknowledge rising while the count is zero;
- the correct acknowledge level just after a transfer in demand, handshake and whole-service modes.

Only the bench scenarios can show the end-to-end behaviour:

- the exact three-edge synchroniser latency;
- that handshake mode waits for a fresh request rise;
- the number of beats per atomic transfer and of transfers per request;
- that the synchroniser select leaves timing unchanged.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int CW_HANDSHAKE = 31;
  localparam int CW_SYNC_SEL  = 30;
  localparam int CW_IRQ_EN    = 29;
  localparam int CW_BURST     = 28;
  localparam int CW_WHOLE     = 27;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BEAT   = 2'd1,
    ST_HSWAIT = 2'd2
  } seq_state_e;

  // number of beats in one atomic transfer
  function automatic int beats_in_atomic(input logic burst, input int burst_len);
    return burst ? burst_len : 1;
  endfunction

endpackage

// File: rtl/dma_seq_sync.sv
module dma_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else if (g == 0) sh_q[g] <= d_i;
        else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dma_seq_counter.sv
module dma_seq_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             hits_zero;

  assign hits_zero = dec_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (load_i)     cnt_q <= load_val_i;
      else if (dec_i) cnt_q <= cnt_q - CNT_W'(1);
      irq_q <= hits_zero && irq_en_i;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dreq_s_i,
  input  logic             beat_done_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             hs_mode_i,
  input  logic             burst_i,
  input  logic             whole_i,
  output logic             dack_o,
  output logic             beat_req_o,
  output logic             xfer_done_o
);
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  seq_state_e st_q, st_d;
  logic [BW-1:0] beat_q;
  logic          last_beat;
  logic          xfer_done;

  assign last_beat = (int'(beat_q) + 1) == beats_in_atomic(burst_i, BURST_LEN);

  always_comb begin
    st_d      = st_q;
    xfer_done = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (dreq_s_i && count_i != '0) st_d = ST_BEAT;
      ST_BEAT: begin
        if (beat_done_i && last_beat) begin
          xfer_done = 1'b1;
          if (count_i == CNT_W'(1)) st_d = ST_IDLE;
          else if (whole_i)         st_d = ST_BEAT;
          else if (hs_mode_i)       st_d = ST_HSWAIT;
          else                      st_d = ST_IDLE;
        end
      end
      ST_HSWAIT: if (!dreq_s_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_BEAT && beat_done_i)
        beat_q <= last_beat ? '0 : beat_q + BW'(1);
    end
  end

  assign dack_o      = (st_q != ST_IDLE);
  assign beat_req_o  = (st_q == ST_BEAT);
  assign xfer_done_o = xfer_done;
endmodule

// File: rtl/dma_req_ack_seq.sv
module dma_req_ack_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_init_i,
  input  logic [31:0]      ctrl_i,
  input  logic             dreq_i,
  output logic             dack_o,
  output logic             beat_req_o,
  input  logic             beat_done_i,
  output logic [CNT_W-1:0] cur_count_o,
  output logic [31:0]      ctrl_o,
  output logic             tc_irq_o
);
  logic [31:0] ctrl_q;
  logic        dreq_s;
  logic        dack_w;
  logic        xfer_done_w;
  logic        load_w;

  assign load_w = start_i && !dack_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (load_w) ctrl_q <= ctrl_i;
  end

  dma_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk), .rst_n (rst_n), .d_i (dreq_i), .q_o (dreq_s)
  );

  dma_seq_fsm #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreq_s_i    (dreq_s),
    .beat_done_i (beat_done_i),
    .count_i     (cur_count_o),
    .hs_mode_i   (ctrl_q[CW_HANDSHAKE]),
    .burst_i     (ctrl_q[CW_BURST]),
    .whole_i     (ctrl_q[CW_WHOLE]),
    .dack_o      (dack_w),
    .beat_req_o  (beat_req_o),
    .xfer_done_o (xfer_done_w)
  );

  dma_seq_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .load_val_i (count_init_i),
    .dec_i      (xfer_done_w),
    .irq_en_i   (ctrl_q[CW_IRQ_EN]),
    .count_o    (cur_count_o),
    .irq_o      (tc_irq_o)
  );

  assign dack_o = dack_w;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/dma_req_ack_seq_chk.sv
module dma_req_ack_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dack,
  input logic             beat_req,
  input logic             tc_irq,
  input logic [CNT_W-1:0] cur_count,
  input logic [31:0]      ctrl,
  input logic             xfer_done
);
  p_beat_in_dack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_req |-> dack);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);

  p_irq_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |-> (cur_count == '0) && ctrl[29]);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> cur_count == CNT_W'($past(cur_count) - CNT_W'(1)));

  p_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !dack) |=> !dack);

  p_demand_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ctrl[31] && !ctrl[27]) |=> !dack);

  p_hs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl[31] && !ctrl[27] && cur_count != CNT_W'(1)) |=> dack);

  p_whole_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl[27] && cur_count != CNT_W'(1)) |=> dack && beat_req);
endmodule

bind dma_req_ack_seq dma_req_ack_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack      (dack_o),
  .beat_req  (beat_req_o),
  .tc_irq    (tc_irq_o),
  .cur_count (cur_count_o),
  .ctrl      (ctrl_o),
  .xfer_done (xfer_done_w)
);

// File: tb/dma_req_ack_seq_tb_top.sv
module dma_req_ack_seq_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] count_init_i = '0;
  logic [31:0]      ctrl_i = '0;
  logic             dreq_i = 1'b0;
  logic             beat_done_i = 1'b0;
  logic             dack_o, beat_req_o, tc_irq_o;
  logic [CNT_W-1:0] cur_count_o;
  logic [31:0]      ctrl_o;

  always #2.5 clk = ~clk;

  dma_req_ack_seq #(.CNT_W(CNT_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .count_init_i (count_init_i),
    .ctrl_i (ctrl_i), .dreq_i (dreq_i), .dack_o (dack_o), .beat_req_o (beat_req_o),
    .beat_done_i (beat_done_i), .cur_count_o (cur_count_o), .ctrl_o (ctrl_o),
    .tc_irq_o (tc_irq_o)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int beats = 0;
  int rises = 0;
  int irqs = 0;
  logic prev_dack = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // behavioural reference: phase 0 idle, 1 moving beats, 2 waiting for request low
  int   m_phase = 0;
  int   m_beat = 0;
  int   m_cnt = 0;
  logic [31:0] m_ctrl = '0;
  logic m_irq = 1'b0;
  logic [1:0] m_syncq = '0;
  int   n_phase, n_beat, n_cnt;
  logic n_irq;

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_beat = 0; m_cnt = 0; m_ctrl = '0; m_irq = 1'b0; m_syncq = '0;
    end else begin
      if (beat_req_o && beat_done_i) beats++;
      n_phase = m_phase; n_beat = m_beat; n_cnt = m_cnt; n_irq = 1'b0;
      if (m_phase == 0) begin
        if (m_syncq[1] && m_cnt > 0) n_phase = 1;
      end else if (m_phase == 1) begin
        if (beat_done_i) begin
          if (m_beat + 1 == (m_ctrl[28] ? 4 : 1)) begin
            n_beat = 0;
            n_cnt  = m_cnt - 1;
            if (n_cnt == 0) begin
              n_phase = 0;
              n_irq   = m_ctrl[29];
            end else if (m_ctrl[27]) n_phase = 1;
            else if (m_ctrl[31])     n_phase = 2;
            else                     n_phase = 0;
          end else n_beat = m_beat + 1;
        end
      end else begin
        if (!m_syncq[1]) n_phase = 0;
      end
      if (start_i && m_phase == 0) begin
        n_cnt  = int'(count_init_i);
        m_ctrl = ctrl_i;
      end
      m_phase = n_phase; m_beat = n_beat; m_cnt = n_cnt; m_irq = n_irq;
      m_syncq = {m_syncq[0], dreq_i};
    end
  end

  // per-cycle comparison, bus responder and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R4 R5 R8 R10 dack", dack_o, m_phase != 0);
      check("R6 beat_req", beat_req_o, m_phase == 1);
      check("R9 count", cur_count_o, m_cnt);
      check("R9 tc_irq", tc_irq_o, m_irq);
      check("R2 ctrl", ctrl_o, m_ctrl);
      if (dack_o && !prev_dack) rises++;
      if (tc_irq_o) irqs++;
      prev_dack = dack_o;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    beat_done_i <= beat_req_o && lfsr[0];
    if (cyc == 20000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] cw, input int cnt);
    @(negedge clk);
    ctrl_i = cw; count_init_i = CNT_W'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_count(input int val);
    for (int i = 0; i < 2000 && int'(cur_count_o) != val; i++) @(negedge clk);
  endtask

  task automatic wait_dack(input logic val);
    for (int i = 0; i < 2000 && dack_o != val; i++) @(negedge clk);
  endtask

  int r0, b0;

  initial begin
    step(3);
    // R1: reset state
    check("R1 dack", dack_o, 0);
    check("R1 beat_req", beat_req_o, 0);
    check("R1 count", cur_count_o, 0);
    check("R1 irq", tc_irq_o, 0);
    check("R1 ctrl", ctrl_o, 0);
    rst_n = 1'b1;
    step(2);

    // demand, single, one beat, no irq
    load(32'h0000_0000, 3);
    check("R2 count load", cur_count_o, 3);
    check("R2 ctrl load", ctrl_o, 0);
    r0 = rises;
    dreq_i = 1'b1;
    step(2);
    check("R3 dack before sync", dack_o, 0);
    step(1);
    check("R3 dack after sync", dack_o, 1);
    wait_count(0);
    step(2);
    check("R7 R5 atomics per request", rises - r0, 3);
    step(10);
    check("R10 dack held low at zero", dack_o, 0);
    check("R9 no irq when disabled", irqs, 0);
    dreq_i = 1'b0;
    step(4);

    // handshake, burst, irq
    load(32'hB000_0000, 2);
    check("R2 ctrl hs", ctrl_o, 32'hB000_0000);
    b0 = beats;
    dreq_i = 1'b1;
    wait_count(1);
    step(5);
    check("R4 dack held while request high", dack_o, 1);
    check("R6 four beats per burst", beats - b0, 4);
    dreq_i = 1'b0;
    step(4);
    check("R4 dack drops after request low", dack_o, 0);
    step(6);
    check("R4 no new transfer without rise", cur_count_o, 1);
    dreq_i = 1'b1;
    wait_count(0);
    step(2);
    check("R6 eight beats total", beats - b0, 8);
    check("R9 one irq pulse", irqs, 1);
    dreq_i = 1'b0;
    step(4);

    // whole service, single beat, sync select set
    load(32'h4800_0000, 4);
    r0 = rises; b0 = beats;
    dreq_i = 1'b1;
    wait_dack(1'b1);
    dreq_i = 1'b0;
    wait_count(0);
    step(2);
    check("R8 single acknowledge for whole run", rises - r0, 1);
    check("R8 R11 four single beats", beats - b0, 4);
    check("R9 no irq bit29 clear", irqs, 1);

    // zero count start, then reload
    dreq_i = 1'b1;
    load(32'h0000_0000, 0);
    step(8);
    check("R10 zero load stays idle", dack_o, 0);
    load(32'h2000_0000, 2);
    wait_count(0);
    step(2);
    check("R10 reload resumes service", cur_count_o, 0);
    check("R9 irq after reload", irqs, 2);
    dreq_i = 1'b0;
    step(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule